// File: doc/BRIEF.md
# Window Watchdog Timer Controller

This block watches a periodic service strobe from software or a companion controller. Only the falling edges of that strobe count, and each one is called a kick. Once the first kick has been seen, every later kick has to arrive inside a timing window that has both a lower and an upper bound. A kick that comes too early is treated the same as one that never comes: either way the block pulls an active-low fault flag down for a fixed hold time, then lets it go. A two-bit mode select picks one of four preset pairs of window bounds. Every pair is given as a clock-tick count, so the nominal millisecond times can be scaled to whatever clock drives the block.

The block only acts while an enable level is high and a "system reset asserted" level is low. Outside that state it ignores the strobe and releases its output, and it marks the output as undriven through an output-enable that stands in for an open-drain pad. Each time the block becomes active it waits out a short setup period and then starts in first-kick mode. In that mode only the upper bound is checked. The same first-kick mode is entered again after every fault hold.

Top module: `wwdt_ctrl`

## Requirements
- R1: Only a falling edge of `kick_i` counts as a kick. Rising edges and steady levels never change the window count or raise a fault. The edge passes through a two-stage synchroniser, so a kick first sampled low at clock edge S is judged at edge S+2. It is judged against the count m = S+1-W, where W is the edge at which the current window began (the count is 0 at W).
- R2: In first-kick mode a kick with m below HI is accepted whatever its value, even below LO. A new window then begins at the judging edge and normal mode starts.
- R3: In normal mode a kick with LO <= m <= HI-1 is accepted. A new window begins at the judging edge and no fault is raised.
- R4: In normal mode a kick with m < LO is an early fault. `fault_n_o` goes low at the judging edge.
- R5: If no kick has been judged by count HI-1, `fault_n_o` goes low at edge W+HI. This applies in both first-kick mode and normal mode.
- R6: A fault holds `fault_n_o` low for exactly HOLD_TICKS cycles (default 25). The output then returns high and a new first-kick window begins at the release edge.
- R7: While `enable_i` is low or `sys_rst_i` is high, `fault_oe_o` is 0 and `fault_n_o` is 1 in the same cycle, and kicks have no effect.
- R8: When the block becomes active in the cycle before edge A, it spends SETUP_TICKS cycles (default 3) in a setup period and ignores kicks during it. The first window begins at edge A+SETUP_TICKS.
- R9: `mode_i` selects the bounds (LO, HI) in ticks. The defaults are: 0 gives 40/80, 1 gives 5/30, 2 gives 10/24, 3 gives 20/64. Mode 0 is the long preset, with a 1:2 ratio. Mode 1 is the short preset, with about a 1:6 ratio.
- R10: Out of reset, with the block inactive, `fault_oe_o` is 0 and `fault_n_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| kick_i | input | 1 | Asynchronous service strobe; falling edges are kicks |
| enable_i | input | 1 | Watchdog enable level |
| sys_rst_i | input | 1 | High while the surrounding system is held in reset |
| mode_i | input | 2 | Window preset select |
| fault_n_o | output | 1 | Active-low fault flag |
| fault_oe_o | output | 1 | 1 when the fault pad is driven by the watchdog, 0 for high impedance |

## Verification
Two events can fall on the same edge: the upper bound expiring and a kick being judged, when a kick arrives with m equal to HI-1. The bench creates this case in first-kick mode and in normal mode by timing the falling edge of the strobe three cycles ahead of the judging edge. It requires the kick to win, with no fault and a window restart. The bench also puts the lower boundary next to the upper one, trying m = LO-1 and m = LO. Deactivation is driven in the middle of a fault hold, and the bench expects the flag to release in that same cycle.

// File: rtl/wwdt_pkg.sv
package wwdt_pkg;

  typedef enum logic [2:0] {
    WD_IDLE  = 3'd0,
    WD_SETUP = 3'd1,
    WD_FIRST = 3'd2,
    WD_WIN   = 3'd3,
    WD_HOLD  = 3'd4
  } wd_state_e;

  function automatic int unsigned wd_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/wwdt_rst_sync.sv
module wwdt_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] rs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rs_q <= 2'b00;
    else         rs_q <= {rs_q[0], 1'b1};
  end

  assign rst_no = rs_q[1];
endmodule

// File: rtl/wwdt_edge_sync.sv
module wwdt_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic fall_o
);
  logic [STAGES-1:0] sy_q;
  logic [STAGES-1:0] sy_d;
  logic              prev_q;

  always_comb begin
    sy_d = {sy_q[STAGES-2:0], async_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sy_q   <= '1;
      prev_q <= 1'b1;
    end else begin
      sy_q   <= sy_d;
      prev_q <= sy_q[STAGES-1];
    end
  end

  assign fall_o = prev_q & ~sy_q[STAGES-1];
endmodule

// File: rtl/wwdt_window_sel.sv
module wwdt_window_sel #(
  parameter int unsigned CW    = 8,
  parameter int unsigned LO_M0 = 40,
  parameter int unsigned HI_M0 = 80,
  parameter int unsigned LO_M1 = 5,
  parameter int unsigned HI_M1 = 30,
  parameter int unsigned LO_M2 = 10,
  parameter int unsigned HI_M2 = 24,
  parameter int unsigned LO_M3 = 20,
  parameter int unsigned HI_M3 = 64
) (
  input  logic [1:0]    mode_i,
  output logic [CW-1:0] lo_o,
  output logic [CW-1:0] hi_o
);
  localparam int unsigned NMODES = 4;
  localparam int unsigned LO_TAB [NMODES] = '{LO_M0, LO_M1, LO_M2, LO_M3};
  localparam int unsigned HI_TAB [NMODES] = '{HI_M0, HI_M1, HI_M2, HI_M3};

  logic [CW-1:0] lo_tab [NMODES];
  logic [CW-1:0] hi_tab [NMODES];

  for (genvar g = 0; g < NMODES; g++) begin : g_tab
    assign lo_tab[g] = CW'(LO_TAB[g]);
    assign hi_tab[g] = CW'(HI_TAB[g]);
  end

  assign lo_o = lo_tab[mode_i];
  assign hi_o = hi_tab[mode_i];
endmodule

// File: rtl/wwdt_core.sv
module wwdt_core
  import wwdt_pkg::*;
#(
  parameter int unsigned CW          = 8,
  parameter int unsigned HOLD_TICKS  = 25,
  parameter int unsigned SETUP_TICKS = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          active_i,
  input  logic          kick_fall_i,
  input  logic [CW-1:0] lo_i,
  input  logic [CW-1:0] hi_i,
  output wd_state_e     state_o,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] SETUP_LAST = CW'(SETUP_TICKS - 1);
  localparam logic [CW-1:0] HOLD_LAST  = CW'(HOLD_TICKS - 1);
  localparam logic [CW-1:0] ONE        = CW'(1);

  wd_state_e     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic [CW-1:0] hi_last;

  assign hi_last = hi_i - ONE;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q + ONE;
    if (!active_i) begin
      st_d  = WD_IDLE;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        WD_IDLE: begin
          st_d  = WD_SETUP;
          cnt_d = '0;
        end
        WD_SETUP: begin
          if (cnt_q >= SETUP_LAST) begin
            st_d  = WD_FIRST;
            cnt_d = '0;
          end
        end
        WD_FIRST: begin
          if (kick_fall_i) begin
            st_d  = WD_WIN;
            cnt_d = '0;
          end else if (cnt_q >= hi_last) begin
            st_d  = WD_HOLD;
            cnt_d = '0;
          end
        end
        WD_WIN: begin
          if (kick_fall_i) begin
            st_d  = (cnt_q < lo_i) ? WD_HOLD : WD_WIN;
            cnt_d = '0;
          end else if (cnt_q >= hi_last) begin
            st_d  = WD_HOLD;
            cnt_d = '0;
          end
        end
        WD_HOLD: begin
          if (cnt_q >= HOLD_LAST) begin
            st_d  = WD_FIRST;
            cnt_d = '0;
          end
        end
        default: begin
          st_d  = WD_IDLE;
          cnt_d = '0;
        end
      endcase
    end
  end

  assign cnt_en = active_i || (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= WD_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign state_o = st_q;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/wwdt_ctrl.sv
module wwdt_ctrl
  import wwdt_pkg::*;
#(
  parameter int unsigned LO_M0       = 40,
  parameter int unsigned HI_M0       = 80,
  parameter int unsigned LO_M1       = 5,
  parameter int unsigned HI_M1       = 30,
  parameter int unsigned LO_M2       = 10,
  parameter int unsigned HI_M2       = 24,
  parameter int unsigned LO_M3       = 20,
  parameter int unsigned HI_M3       = 64,
  parameter int unsigned HOLD_TICKS  = 25,
  parameter int unsigned SETUP_TICKS = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       kick_i,
  input  logic       enable_i,
  input  logic       sys_rst_i,
  input  logic [1:0] mode_i,
  output logic       fault_n_o,
  output logic       fault_oe_o
);
  localparam int unsigned HI_MAX  = wd_max(wd_max(HI_M0, HI_M1), wd_max(HI_M2, HI_M3));
  localparam int unsigned CNT_MAX = wd_max(HI_MAX, wd_max(HOLD_TICKS, SETUP_TICKS));
  localparam int unsigned CW      = $clog2(CNT_MAX + 1);

  logic          rst_n;
  logic          kick_fall;
  logic          active;
  logic [CW-1:0] lo;
  logic [CW-1:0] hi;
  wd_state_e     st;
  logic [CW-1:0] cnt;

  assign active = enable_i & ~sys_rst_i;

  wwdt_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  wwdt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .async_i (kick_i),
    .fall_o  (kick_fall)
  );

  wwdt_window_sel #(
    .CW(CW),
    .LO_M0(LO_M0), .HI_M0(HI_M0), .LO_M1(LO_M1), .HI_M1(HI_M1),
    .LO_M2(LO_M2), .HI_M2(HI_M2), .LO_M3(LO_M3), .HI_M3(HI_M3)
  ) u_sel (
    .mode_i (mode_i),
    .lo_o   (lo),
    .hi_o   (hi)
  );

  wwdt_core #(
    .CW(CW), .HOLD_TICKS(HOLD_TICKS), .SETUP_TICKS(SETUP_TICKS)
  ) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .active_i    (active),
    .kick_fall_i (kick_fall),
    .lo_i        (lo),
    .hi_i        (hi),
    .state_o     (st),
    .cnt_o       (cnt)
  );

  assign fault_n_o  = !((st == WD_HOLD) && active);
  assign fault_oe_o = active;
endmodule

// File: rtl/wwdt_chk.sv
module wwdt_chk
  import wwdt_pkg::*;
#(
  parameter int unsigned CW         = 8,
  parameter int unsigned HOLD_TICKS = 25
) (
  input logic          clk,
  input logic          rst_n,
  input logic          active,
  input logic          kick_fall,
  input wd_state_e     st,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] lo,
  input logic [CW-1:0] hi,
  input logic          fault_n,
  input logic          fault_oe
);
  int run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             run <= 0;
    else if (st == WD_HOLD) run <= run + 1;
    else                    run <= 0;
  end

  // R7: inactive means released and undriven
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (fault_n && !fault_oe));

  // R2: first kick accepted regardless of the lower bound
  p_first_any_r2: assert property (@(posedge clk) disable iff (!rst_n || !active)
    (st == WD_FIRST && kick_fall) |=> (st == WD_WIN && cnt == '0));

  // R3: in-window kick restarts the window
  p_inwin_r3: assert property (@(posedge clk) disable iff (!rst_n || !active)
    (st == WD_WIN && kick_fall && cnt >= lo && cnt < hi) |=> (st == WD_WIN && cnt == '0));

  // R4: early kick faults
  p_early_r4: assert property (@(posedge clk) disable iff (!rst_n || !active)
    (st == WD_WIN && kick_fall && cnt < lo) |=> (st == WD_HOLD && !fault_n));

  // R5: missing kick faults at the upper bound
  p_late_r5: assert property (@(posedge clk) disable iff (!rst_n || !active)
    ((st == WD_WIN || st == WD_FIRST) && !kick_fall && cnt >= hi - CW'(1)) |=> (st == WD_HOLD));

  // R6: hold never outlasts its period and ends in first-kick mode
  p_hold_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == WD_HOLD) |-> (run < HOLD_TICKS));

  p_hold_exit_r6: assert property (@(posedge clk) disable iff (!rst_n || !active)
    (st == WD_HOLD && run == HOLD_TICKS - 1) |=> (st == WD_FIRST && fault_n));

  // R8: setup period never jumps to a checked window or a fault
  p_setup_deaf_r8: assert property (@(posedge clk) disable iff (!rst_n || !active)
    (st == WD_SETUP) |=> (st != WD_WIN && st != WD_HOLD));

  // R1: without a falling edge the window keeps counting
  p_rise_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n || !active)
    (st == WD_WIN && !kick_fall && cnt < hi - CW'(1)) |=> (st == WD_WIN && cnt == CW'($past(cnt) + 1'b1)));
endmodule

bind wwdt_ctrl wwdt_chk #(.CW(CW), .HOLD_TICKS(HOLD_TICKS)) u_chk (
  .clk       (clk_i),
  .rst_n     (rst_n),
  .active    (active),
  .kick_fall (kick_fall),
  .st        (st),
  .cnt       (cnt),
  .lo        (lo),
  .hi        (hi),
  .fault_n   (fault_n_o),
  .fault_oe  (fault_oe_o)
);

// File: tb/tb_wwdt_ctrl.sv
module tb_wwdt_ctrl;
  localparam int HOLD  = 25;
  localparam int SETUP = 3;

  logic       clk;
  logic       rst_n;
  logic       kick;
  logic       en;
  logic       srst;
  logic [1:0] mode;
  logic       fault_n;
  logic       oe;

  int cyc;
  int tests;
  int fails;
  int win;
  int lo;
  int hi;
  bit first;
  bit done;

  wwdt_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .kick_i(kick), .enable_i(en),
    .sys_rst_i(srst), .mode_i(mode), .fault_n_o(fault_n), .fault_oe_o(oe)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int lo_of(input logic [1:0] md);
    case (md)
      2'd0: return 40;
      2'd1: return 5;
      2'd2: return 10;
      default: return 20;
    endcase
  endfunction

  function automatic int hi_of(input logic [1:0] md);
    case (md)
      2'd0: return 80;
      2'd1: return 30;
      2'd2: return 24;
      default: return 64;
    endcase
  endfunction

  function automatic bit kick_ok(input bit frst, input int m, input int l, input int h);
    return frst ? (m < h) : (m >= l && m < h);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: got %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  task automatic wait_to(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic activate(input logic [1:0] md);
    mode  = md;
    lo    = lo_of(md);
    hi    = hi_of(md);
    en    = 1'b1;
    win   = cyc + 1 + SETUP;
    first = 1'b1;
  endtask

  task automatic finish_hold(input int s);
    wait_to(s + HOLD - 1);
    chk("R6 hold still low", fault_n, 0);
    wait_to(s + HOLD);
    chk("R6 hold released", fault_n, 1);
    win   = s + HOLD;
    first = 1'b1;
  endtask

  task automatic late(input string tag);
    wait_to(win + hi - 1);
    chk({tag, " no fault before bound"}, fault_n, 1);
    wait_to(win + hi);
    chk({tag, " late fault R5"}, fault_n, 0);
    finish_hold(win + hi);
  endtask

  task automatic kick_at(input int m, input string tag, input bit keep_low);
    int d;
    bit ok;
    ok = kick_ok(first, m, lo, hi);
    d  = win + m + 1;
    wait_to(win + m - 2);
    kick = 1'b0;
    @(negedge clk);
    if (!keep_low) kick = 1'b1;
    wait_to(d - 1);
    chk({tag, " before judge"}, fault_n, 1);
    wait_to(d);
    if (ok) begin
      chk({tag, " accepted"}, fault_n, 1);
      win   = d;
      first = 1'b0;
    end else begin
      chk({tag, " early fault R4"}, fault_n, 0);
      finish_hold(d);
    end
  endtask

  initial begin
    done = 1'b0;
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    tests = 0;
    fails = 0;
    void'($urandom(32'd4711));
    rst_n = 1'b0;
    kick  = 1'b1;
    en    = 1'b0;
    srst  = 1'b0;
    mode  = 2'd0;
    repeat (3) @(negedge clk);
    chk("R10 reset oe", oe, 0);
    chk("R10 reset fault_n", fault_n, 1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R10 after reset oe", oe, 0);

    // R8: kick during setup is ignored; first window starts on time
    activate(2'd1);
    kick = 1'b0;
    @(negedge clk);
    kick = 1'b1;
    chk("R7 oe active", oe, 1);
    late("R8 setup kick ignored");

    // R2: early first kick accepted; R3/R4 lower boundary
    kick_at(3, "R2 first below LO", 1'b0);
    kick_at(lo, "R3 m=LO", 1'b0);
    kick_at(lo - 1, "R4 m=LO-1", 1'b0);
    // kick coinciding with bound expiry, first and normal mode
    kick_at(hi - 1, "R2 m=HI-1", 1'b0);
    kick_at(hi - 1, "R3 m=HI-1", 1'b0);
    late("R5 normal");

    // R1: rising edge in the early region is ignored
    kick_at(4, "R1 setup kick", 1'b1);
    wait_to(win + 2);
    kick = 1'b1;
    wait_to(win + lo - 1);
    chk("R1 rise ignored", fault_n, 1);
    kick_at(lo + 2, "R1 valid after rise", 1'b0);

    // R7: disable during a fault hold releases at once
    begin
      int d;
      d = win + 2 + 1;
      wait_to(win);
      kick = 1'b0;
      @(negedge clk);
      kick = 1'b1;
      wait_to(d);
      chk("R4 early before disable", fault_n, 0);
      @(negedge clk);
      en = 1'b0;
      #1;
      chk("R7 disable releases", fault_n, 1);
      chk("R7 disable oe", oe, 0);
      kick = 1'b0;
      repeat (3) @(negedge clk);
      kick = 1'b1;
      repeat (3) @(negedge clk);
      chk("R7 kicks ignored while off", fault_n, 1);
    end
    activate(2'd2);
    late("R8 fresh window R9 mode2");

    // R7: system reset level
    kick_at(12, "R9 mode2 valid", 1'b0);
    @(negedge clk);
    srst = 1'b1;
    #1;
    chk("R7 sysrst oe", oe, 0);
    kick = 1'b0;
    repeat (2) @(negedge clk);
    kick = 1'b1;
    repeat (4) @(negedge clk);
    chk("R7 sysrst fault_n", fault_n, 1);
    srst  = 1'b0;
    win   = cyc + 1 + SETUP;
    first = 1'b1;
    kick_at(4, "R2 after sysrst", 1'b0);
    kick_at(2, "R4 after sysrst", 1'b0);

    // random sessions
    for (int s = 0; s < 6; s++) begin
      en = 1'b0;
      @(negedge clk);
      chk("R7 off", oe, 0);
      repeat (3) @(negedge clk);
      activate(2'($urandom_range(0, 3)));
      for (int k = 0; k < 8; k++) begin
        int cat;
        int m;
        cat = $urandom_range(0, 4);
        case (cat)
          0: m = $urandom_range(2, lo - 1);
          1, 2: m = $urandom_range(lo, hi - 1);
          3: begin
            case ($urandom_range(0, 2))
              0: m = lo - 1;
              1: m = lo;
              default: m = hi - 1;
            endcase
          end
          default: m = -1;
        endcase
        if (m < 0) late("R9 random");
        else if (first) kick_at(m, "R9 random R2", 1'b0);
        else if (m < lo) kick_at(m, "R9 random R4", 1'b0);
        else kick_at(m, "R9 random R3", 1'b0);
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule